// File: doc/BRIEF.md
# Word and Doubleword Rotate-Right Unit

This unit executes the rotate-right instructions of a register-type integer instruction word. It receives a 64-bit source operand, the low bits of the register that may carry a rotate amount, and three fields of the instruction: the 5-bit first-register field, the 5-bit shift-amount field and the 6-bit function code. From these it picks one of five rotate forms:

- a 32-bit rotate by an immediate amount;
- a 32-bit rotate by a register amount;
- a 64-bit rotate by an immediate amount;
- a 64-bit rotate by an immediate amount plus 32, so that a 5-bit field can reach rotations of 32 to 63;
- a 64-bit rotate by a register amount.

The unit then produces the rotated value. An instruction that matches none of the forms is passed through with a flag, so that the issue logic can send it elsewhere.

Operations enter and leave on valid/ready streams, and one output register sits between them. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is held in the output register and shows on `out_valid`/`out_data` from the next cycle. It stays there, unchanged, until a clock edge where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A new operation can therefore be accepted on the same edge that the previous result leaves, and the unit sustains one operation per cycle.

Top module: `rot_unit`

## Requirements
- R1: Function code 000010 with the first-register field equal to 00001 rotates the low 32 bits of `in_src` right by the shift-amount field. The 32-bit result goes to `out_data[31:0]`, and bit 31 of that result is copied into `out_data[63:32]`.
- R2: Function code 000110 with the shift-amount field equal to 00001 rotates the low 32 bits right by `in_amt[4:0]`, with the same sign extension as R1. `in_amt[5]` has no effect.
- R3: Function code 111010 with the first-register field equal to 00001 rotates all 64 bits of `in_src` right by the shift-amount field (0 to 31).
- R4: Function code 111110 with the first-register field equal to 00001 rotates all 64 bits right by the shift-amount field plus 32 (32 to 63).
- R5: Function code 010110 with the shift-amount field equal to 00001 rotates all 64 bits right by `in_amt[5:0]` (0 to 63).
- R6: A rotate amount of zero returns the source unchanged. For the 64-bit forms this is all of `in_src`. For the 32-bit forms it is the low word, sign-extended as in R1.
- R7: Any other combination of the three fields gives `out_bad` = 1 with `out_data` = 0. Every valid form gives `out_bad` = 0.
- R8: An operation accepted at a clock edge makes `out_valid` high, with its result, immediately after that edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_bad` hold their values and `in_ready` is low. An offered operation waits and is not lost.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take the offered operation |
| in_src | input | 64 | Source operand to rotate |
| in_amt | input | 6 | Low bits of the register carrying a variable amount |
| in_rs_fld | input | 5 | First-register field of the instruction |
| in_sa_fld | input | 5 | Shift-amount field of the instruction |
| in_fn_fld | input | 6 | Function code of the instruction |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the held result |
| out_data | output | 64 | Rotated result |
| out_bad | output | 1 | The instruction is not a rotate of this unit |

## Verification
Two events can fall on the same clock edge: a held result being drained and a new operation being accepted. The bench provokes this by stalling the output with a result held, offering a second operation behind it and checking that it is refused and that the held value does not move. It then raises `out_ready`, so that both handshakes happen on one edge. The bench judges the outcome by expecting the second result alone on the next cycle, with `out_valid` still high. This shows that nothing was dropped or duplicated.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int unsigned FLD_W = 5;
  localparam int unsigned FN_W  = 6;

  localparam logic [FLD_W-1:0] MARK      = 5'b00001;
  localparam logic [FN_W-1:0]  FN_W_IMM  = 6'b000010;
  localparam logic [FN_W-1:0]  FN_W_VAR  = 6'b000110;
  localparam logic [FN_W-1:0]  FN_D_IMM  = 6'b111010;
  localparam logic [FN_W-1:0]  FN_D_IMM2 = 6'b111110;
  localparam logic [FN_W-1:0]  FN_D_VAR  = 6'b010110;

  typedef enum logic [2:0] {
    K_NONE, K_W_IMM, K_W_VAR, K_D_IMM, K_D_IMM2, K_D_VAR
  } rot_kind_e;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic [AW-1:0]    amt_reg,
  input  logic [FLD_W-1:0] rs_fld,
  input  logic [FLD_W-1:0] sa_fld,
  input  logic [FN_W-1:0]  fn_fld,
  output rot_kind_e        kind,
  output logic             hit,
  output logic             is_word,
  output logic [AW-1:0]    amt
);
  localparam int unsigned WAW = AW - 1;

  always_comb begin
    kind = K_NONE;
    if (rs_fld == MARK && fn_fld == FN_W_IMM)  kind = K_W_IMM;
    if (sa_fld == MARK && fn_fld == FN_W_VAR)  kind = K_W_VAR;
    if (rs_fld == MARK && fn_fld == FN_D_IMM)  kind = K_D_IMM;
    if (rs_fld == MARK && fn_fld == FN_D_IMM2) kind = K_D_IMM2;
    if (sa_fld == MARK && fn_fld == FN_D_VAR)  kind = K_D_VAR;
  end

  always_comb begin
    amt = '0;
    unique case (kind)
      K_W_IMM:  amt = {1'b0, sa_fld[WAW-1:0]};
      K_W_VAR:  amt = {1'b0, amt_reg[WAW-1:0]};
      K_D_IMM:  amt = {1'b0, sa_fld[WAW-1:0]};
      K_D_IMM2: amt = {1'b1, sa_fld[WAW-1:0]};
      K_D_VAR:  amt = amt_reg;
      default:  amt = '0;
    endcase
  end

  assign hit     = (kind != K_NONE);
  assign is_word = (kind == K_W_IMM) || (kind == K_W_VAR);
endmodule

// File: rtl/rot_core.sv
module rot_core #(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = $clog2(DW)
) (
  input  logic [DW-1:0] src,
  input  logic [AW-1:0] amt,
  input  logic          is_word,
  input  logic          hit,
  output logic [DW-1:0] res
);
  localparam int unsigned HW = DW / 2;

  logic [2*DW-1:0] dbl_d;
  logic [DW-1:0]   dbl_w;
  logic [DW-1:0]   rot_d;
  logic [DW-1:0]   rot_w;

  assign dbl_d = {src, src} >> amt;
  assign dbl_w = {src[HW-1:0], src[HW-1:0]} >> amt[AW-2:0];
  assign rot_d = dbl_d[DW-1:0];
  assign rot_w = {{HW{dbl_w[HW-1]}}, dbl_w[HW-1:0]};

  always_comb begin
    if (!hit)         res = '0;
    else if (is_word) res = rot_w;
    else              res = rot_d;
  end
endmodule

// File: rtl/rot_out_stage.sv
module rot_out_stage #(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_bad,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_bad
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_bad   <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_bad   <= in_bad;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_TAKE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_bad))); // R9
endmodule

// File: rtl/rot_unit.sv
module rot_unit
  import rot_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_src,
  input  logic [AW-1:0]    in_amt,
  input  logic [FLD_W-1:0] in_rs_fld,
  input  logic [FLD_W-1:0] in_sa_fld,
  input  logic [FN_W-1:0]  in_fn_fld,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_bad
);
  localparam int unsigned HW = DW / 2;

  rot_kind_e     dec_kind;
  logic          dec_hit;
  logic          dec_word;
  logic [AW-1:0] dec_amt;
  logic [DW-1:0] core_res;

  rot_decode #(.AW(AW)) u_dec (
    .amt_reg(in_amt), .rs_fld(in_rs_fld), .sa_fld(in_sa_fld), .fn_fld(in_fn_fld),
    .kind(dec_kind), .hit(dec_hit), .is_word(dec_word), .amt(dec_amt)
  );

  rot_core #(.DW(DW), .AW(AW)) u_core (
    .src(in_src), .amt(dec_amt), .is_word(dec_word), .hit(dec_hit), .res(core_res)
  );

  rot_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(core_res), .in_bad(!dec_hit),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_bad(out_bad)
  );

  AST_WORD_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && dec_word) |=> (out_data[DW-1:HW] == {HW{out_data[HW-1]}})); // R1
  AST_BAD_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bad) |-> (out_data == '0)); // R7
  AST_ZERO_AMT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_fn_fld == FN_D_VAR && in_sa_fld == MARK && in_amt == '0)
      |=> (out_data == $past(in_src))); // R6
endmodule

// File: tb/test_rot_unit.sv
module test_rot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic [5:0]  in_amt = '0;
  logic [4:0]  in_rs_fld = '0;
  logic [4:0]  in_sa_fld = '0;
  logic [5:0]  in_fn_fld = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_bad;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rot_unit i_rot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_amt(in_amt), .in_rs_fld(in_rs_fld), .in_sa_fld(in_sa_fld),
    .in_fn_fld(in_fn_fld), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_bad(out_bad)
  );

  function automatic logic [63:0] m_rot64(logic [63:0] x, int a);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = x[(i + a) % 64];
    return r;
  endfunction

  function automatic logic [63:0] m_rot32(logic [63:0] x, int a);
    logic [63:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[(i + a) % 32];
    for (int i = 32; i < 64; i++) r[i] = r[31];
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [63:0] s, logic [5:0] a, logic [4:0] rs,
                       logic [4:0] sa, logic [5:0] fn);
    @(negedge clk);
    in_valid = 1'b1; in_src = s; in_amt = a;
    in_rs_fld = rs; in_sa_fld = sa; in_fn_fld = fn;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(string req, logic [63:0] s, logic [5:0] a, logic [4:0] rs,
                        logic [4:0] sa, logic [5:0] fn, logic [63:0] exp, logic exp_bad);
    issue(s, a, rs, sa, fn);
    chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
    chk(req, out_data, exp);
    chk({req, " bad"}, {63'd0, out_bad}, {63'd0, exp_bad});
  endtask

  task automatic t_reset;
    chk("R10 valid", {63'd0, out_valid}, 64'd0);
    chk("R10 ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_word;
    logic [63:0] s = 64'h1234_5678_8000_0001;
    run_op("R1 imm 1", s, 6'd0, 5'b00001, 5'd1, 6'b000010, m_rot32(s, 1), 1'b0);
    run_op("R1 imm 31", s, 6'd0, 5'b00001, 5'd31, 6'b000010, m_rot32(s, 31), 1'b0);
    run_op("R2 var 4", 64'hdead_beef_0f0f_00f1, 6'd4, 5'd9, 5'b00001, 6'b000110,
           m_rot32(64'hdead_beef_0f0f_00f1, 4), 1'b0);
    run_op("R2 bit5 ignored", s, 6'd33, 5'd3, 5'b00001, 6'b000110, m_rot32(s, 1), 1'b0);
  endtask

  task automatic t_dword;
    logic [63:0] s = 64'h0123_4567_89ab_cdef;
    run_op("R3 imm 8", s, 6'd0, 5'b00001, 5'd8, 6'b111010, m_rot64(s, 8), 1'b0);
    run_op("R3 imm 31", s, 6'd0, 5'b00001, 5'd31, 6'b111010, m_rot64(s, 31), 1'b0);
    run_op("R4 imm+32 0", s, 6'd0, 5'b00001, 5'd0, 6'b111110, m_rot64(s, 32), 1'b0);
    run_op("R4 imm+32 31", s, 6'd0, 5'b00001, 5'd31, 6'b111110, m_rot64(s, 63), 1'b0);
    run_op("R5 var 45", s, 6'd45, 5'd7, 5'b00001, 6'b010110, m_rot64(s, 45), 1'b0);
    run_op("R5 var 63", s, 6'd63, 5'd7, 5'b00001, 6'b010110, m_rot64(s, 63), 1'b0);
  endtask

  task automatic t_zero;
    logic [63:0] s = 64'hfedc_ba98_7654_3210;
    run_op("R6 dword imm 0", s, 6'd0, 5'b00001, 5'd0, 6'b111010, s, 1'b0);
    run_op("R6 dword var 0", s, 6'd0, 5'd2, 5'b00001, 6'b010110, s, 1'b0);
    run_op("R6 word var 0", s, 6'd0, 5'd2, 5'b00001, 6'b000110, 64'h0000_0000_7654_3210, 1'b0);
  endtask

  task automatic t_bad;
    run_op("R7 marker wrong", 64'hffff_ffff_ffff_ffff, 6'd3, 5'b00010, 5'd3, 6'b000010, 64'd0, 1'b1);
    run_op("R7 var marker wrong", 64'h1, 6'd3, 5'd0, 5'b00000, 6'b010110, 64'd0, 1'b1);
    run_op("R7 unknown fn", 64'h1, 6'd3, 5'b00001, 5'b00001, 6'b100000, 64'd0, 1'b1);
  endtask

  task automatic t_stall;
    logic [63:0] a = 64'h0000_0000_0000_00ff;
    logic [63:0] b = 64'h8000_0000_0000_0000;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_src = a; in_amt = 6'd0;
    in_rs_fld = 5'b00001; in_sa_fld = 5'd4; in_fn_fld = 6'b111010;
    @(negedge clk);
    chk("R8 valid after accept", {63'd0, out_valid}, 64'd1);
    in_src = b; in_sa_fld = 5'd1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 held data", out_data, m_rot64(a, 4));
      chk("R9 ready low", {63'd0, in_ready}, 64'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next valid", {63'd0, out_valid}, 64'd1);
    chk("R9 second result", out_data, m_rot64(b, 1));
    @(negedge clk);
    chk("R8 drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    #1_600_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word();
    t_dword();
    t_zero();
    t_bad();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule